// File: doc/BRIEF.md
# Ray Chord Through a Box

This unit measures how far a ray travels inside a box. Every ray starts at the origin. Its direction arrives as three signed Q8.8 components over a valid/ready handshake. The box is written beforehand through a small register port:
- three face normals, one for each pair of parallel faces;
- six plane constants, each the product of a normal with a point on one face.

For each axis the unit forms the dot product of that axis's normal with the ray direction. A shared sequential restoring divider then computes one reciprocal of that dot product. The two plane constants of the axis are multiplied by the reciprocal, which gives the distances along the ray at which it crosses the two parallel faces.

The six distances are then ordered. The later face of each pair is an exit and the earlier one is an entry. The overall entry is the latest entry, and the overall exit is the earliest exit. The result is a hit flag and a chord length, which is the overall exit minus the overall entry. The result is held at the output until it is taken. Only one ray is in flight at a time.

Top module: `ray_box_chord`

## Requirements
- R1: Box registers are written when `cfg_we` is high at a clock edge. Address 3a+k holds component k (0=x, 1=y, 2=z) of the normal of axis a (a=0..2). Address 9+2a holds the first plane constant of axis a and address 10+2a holds the second. Address 15 changes nothing. All values are signed Q8.8.
- R2: `in_ready` is high only when no ray is in flight. A ray is accepted on a clock edge where both `in_valid` and `in_ready` are high. From the next cycle `in_ready` stays low until the result has been taken.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_hit` and `out_len` keep their values. The result is taken on a clock edge where both are high.
- R4: The per-axis dot product is sat16(floor((nx·rx + ny·ry + nz·rz) / 256)). Here sat16 clamps to the range −32768..32767.
- R5: For a nonzero dot product d, the reciprocal is floor(65536/|d|), clamped to 32767 and given the sign of d.
- R6: The two face distances of an axis are sat16(floor(c·recip/256)), one for each plane constant c. The smaller distance is the axis entry and the larger is the axis exit.
- R7: An axis with d = 0 is parallel to the ray. It passes only if the smaller of its plane constants is ≤ 0 and the larger is ≥ 0. A passing parallel axis contributes entry −32768 and exit 32767. A failing parallel axis forces a miss.
- R8: The overall entry is the maximum of the axis entries and the overall exit is the minimum of the axis exits. A hit requires all of the following:
  - every parallel axis passes;
  - entry ≤ exit, with equality still counting as a hit;
  - exit ≥ 0.
- R9: On a hit `out_len` is sat16(exit − entry). On a miss `out_len` is 0.
- R10: After reset `in_ready` is 1 and `out_valid` is 0, and every box register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Box register write enable |
| cfg_addr | input | 4 | Box register address |
| cfg_wdata | input | 16 | Box register write value, Q8.8 |
| in_valid | input | 1 | Ray direction valid |
| in_ready | output | 1 | Unit can accept a ray |
| in_dir_x | input | 16 | Direction x component, Q8.8 |
| in_dir_y | input | 16 | Direction y component, Q8.8 |
| in_dir_z | input | 16 | Direction z component, Q8.8 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_hit | output | 1 | Ray passes through the box |
| out_len | output | 16 | Chord length, Q8.8 |

## Verification
The rays are chosen to separate different failure sources:
- A ray straight down one axis gives a hand-known chord of 2.0 through an axis-aligned box.
- Reversing that ray puts the whole slab behind the origin, so it must report a miss.
- A ray parallel to a slab that does not contain the origin tells the parallel-axis rule apart from the ordering rule.
- A diagonal ray through an edge makes entry equal exit, which checks the inclusive comparison.

Other rays target the saturation paths:
- A tiny direction drives the reciprocal clamp.
- A huge normal drives the dot-product clamp.
- The all-zero box after reset drives the length clamp.

A sweep of pseudo-random directions then compares every result against an integer model built from the requirements.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int FX_W    = 16;
  localparam int FX_FRAC = 8;
  localparam int NAXIS   = 3;
  localparam int NCOMP   = 3;
  localparam int WIDE_W  = 2 * FX_W + 8;
  localparam int QUO_W   = 2 * FX_FRAC + 1;
  localparam int CFG_AW  = 4;

  typedef logic signed [FX_W-1:0] fx_t;

  localparam fx_t FX_MAX = fx_t'({1'b0, {(FX_W-1){1'b1}}});
  localparam fx_t FX_MIN = fx_t'({1'b1, {(FX_W-1){1'b0}}});

  function automatic fx_t fx_sat(input logic signed [WIDE_W-1:0] v);
    logic signed [WIDE_W-1:0] hi;
    logic signed [WIDE_W-1:0] lo;
    hi = WIDE_W'(FX_MAX);
    lo = WIDE_W'(FX_MIN);
    if (v > hi)      return FX_MAX;
    else if (v < lo) return FX_MIN;
    else             return fx_t'(v[FX_W-1:0]);
  endfunction
endpackage

// File: rtl/rbc_dot.sv
module rbc_dot
  import rbc_pkg::*;
(
  input  fx_t n0,
  input  fx_t n1,
  input  fx_t n2,
  input  fx_t r0,
  input  fx_t r1,
  input  fx_t r2,
  output fx_t dot
);
  logic signed [WIDE_W-1:0] acc;
  logic signed [WIDE_W-1:0] scaled;

  always_comb begin
    acc    = WIDE_W'(n0) * WIDE_W'(r0)
           + WIDE_W'(n1) * WIDE_W'(r1)
           + WIDE_W'(n2) * WIDE_W'(r2);
    scaled = acc >>> FX_FRAC;
    dot    = fx_sat(scaled);
  end
endmodule

// File: rtl/rbc_recip_div.sv
module rbc_recip_div
  import rbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FX_W-1:0]  den,
  output logic             done,
  output logic [QUO_W-1:0] quo
);
  localparam int CW = $clog2(QUO_W + 1);
  localparam logic [QUO_W-1:0] DIVIDEND = QUO_W'(1) << (QUO_W - 1);

  logic [FX_W-1:0]  rem_q, rem_d;
  logic [QUO_W-1:0] qr_q, qr_d;
  logic [FX_W-1:0]  den_q, den_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [FX_W:0]    trial;

  always_comb begin
    rem_d  = rem_q;
    qr_d   = qr_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    trial  = {rem_q, qr_q[QUO_W-1]};
    if (start) begin
      rem_d = '0;
      qr_d  = DIVIDEND;
      den_d = den;
      cnt_d = CW'(QUO_W);
    end else if (cnt_q != '0) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = FX_W'(trial - {1'b0, den_q});
        qr_d  = {qr_q[QUO_W-2:0], 1'b1};
      end else begin
        rem_d = trial[FX_W-1:0];
        qr_d  = {qr_q[QUO_W-2:0], 1'b0};
      end
      cnt_d  = cnt_q - CW'(1);
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      qr_q   <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      qr_q   <= qr_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quo  = qr_q;
endmodule

// File: rtl/rbc_slab_combine.sv
module rbc_slab_combine
  import rbc_pkg::*;
(
  input  fx_t  dot    [NAXIS],
  input  fx_t  rcp    [NAXIS],
  input  fx_t  c_a    [NAXIS],
  input  fx_t  c_b    [NAXIS],
  output logic hit,
  output fx_t  len
);
  fx_t  ent [NAXIS];
  fx_t  ext [NAXIS];
  logic ok  [NAXIS];

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    logic signed [WIDE_W-1:0] pa, pb;
    fx_t ta, tb, cmin, cmax;
    always_comb begin
      pa   = (WIDE_W'(c_a[a]) * WIDE_W'(rcp[a])) >>> FX_FRAC;
      pb   = (WIDE_W'(c_b[a]) * WIDE_W'(rcp[a])) >>> FX_FRAC;
      ta   = fx_sat(pa);
      tb   = fx_sat(pb);
      cmin = (c_a[a] < c_b[a]) ? c_a[a] : c_b[a];
      cmax = (c_a[a] < c_b[a]) ? c_b[a] : c_a[a];
      if (dot[a] == '0) begin
        ent[a] = FX_MIN;
        ext[a] = FX_MAX;
        ok[a]  = (cmin <= 0) && (cmax >= 0);
      end else begin
        ent[a] = (ta < tb) ? ta : tb;
        ext[a] = (ta < tb) ? tb : ta;
        ok[a]  = 1'b1;
      end
    end
  end

  fx_t  tin, tout;
  logic all_ok;
  logic signed [WIDE_W-1:0] span;

  always_comb begin
    tin    = FX_MIN;
    tout   = FX_MAX;
    all_ok = 1'b1;
    for (int a = 0; a < NAXIS; a++) begin
      if (ent[a] > tin)  tin  = ent[a];
      if (ext[a] < tout) tout = ext[a];
      all_ok = all_ok & ok[a];
    end
    hit  = all_ok && (tin <= tout) && (tout >= 0);
    span = WIDE_W'(tout) - WIDE_W'(tin);
    len  = hit ? fx_sat(span) : '0;
  end
endmodule

// File: rtl/ray_box_chord.sv
module ray_box_chord
  import rbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [FX_W-1:0]   cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FX_W-1:0]   in_dir_x,
  input  logic [FX_W-1:0]   in_dir_y,
  input  logic [FX_W-1:0]   in_dir_z,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [FX_W-1:0]   out_len
);
  localparam int AXW      = $clog2(NAXIS);
  localparam int PLN_BASE = NAXIS * NCOMP;

  typedef enum logic [2:0] {ST_IDLE, ST_DIV, ST_WAIT, ST_COMB, ST_OUT} st_e;

  // box registers
  fx_t nrm_q [NAXIS][NCOMP];
  fx_t pla_q [NAXIS];
  fx_t plb_q [NAXIS];

  for (genvar a = 0; a < NAXIS; a++) begin : g_cfg
    for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      logic sel;
      assign sel = cfg_we && (cfg_addr == CFG_AW'(a * NCOMP + k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   nrm_q[a][k] <= '0;
        else if (sel) nrm_q[a][k] <= fx_t'(cfg_wdata);
      end
    end
    logic sel_a, sel_b;
    assign sel_a = cfg_we && (cfg_addr == CFG_AW'(PLN_BASE + 2 * a));
    assign sel_b = cfg_we && (cfg_addr == CFG_AW'(PLN_BASE + 2 * a + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pla_q[a] <= '0;
        plb_q[a] <= '0;
      end else begin
        if (sel_a) pla_q[a] <= fx_t'(cfg_wdata);
        if (sel_b) plb_q[a] <= fx_t'(cfg_wdata);
      end
    end
  end

  // per-axis dot products from the incoming direction
  fx_t dot_w [NAXIS];
  for (genvar a = 0; a < NAXIS; a++) begin : g_dot
    rbc_dot u_dot (
      .n0 (nrm_q[a][0]), .n1 (nrm_q[a][1]), .n2 (nrm_q[a][2]),
      .r0 (fx_t'(in_dir_x)), .r1 (fx_t'(in_dir_y)), .r2 (fx_t'(in_dir_z)),
      .dot(dot_w[a])
    );
  end

  // sequencing state
  st_e            st_q, st_d;
  logic [AXW-1:0] ax_q, ax_d;
  fx_t            dot_q [NAXIS];
  fx_t            dot_d [NAXIS];
  fx_t            rcp_q [NAXIS];
  fx_t            rcp_d [NAXIS];
  logic           hit_q, hit_d;
  fx_t            len_q, len_d;

  logic             div_start;
  logic             div_done;
  logic [QUO_W-1:0] div_quo;
  fx_t              cur_dot;
  logic [FX_W-1:0]  cur_den;
  fx_t              quo_mag;
  fx_t              rcp_new;
  logic             last_ax;
  logic             comb_hit;
  fx_t              comb_len;

  assign cur_dot = dot_q[ax_q];
  assign cur_den = cur_dot[FX_W-1] ? FX_W'(-cur_dot) : FX_W'(cur_dot);
  assign quo_mag = (div_quo > QUO_W'(FX_MAX)) ? FX_MAX : fx_t'(div_quo[FX_W-1:0]);
  assign rcp_new = cur_dot[FX_W-1] ? -quo_mag : quo_mag;
  assign last_ax = (ax_q == AXW'(NAXIS - 1));

  rbc_recip_div u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .den  (cur_den),
    .done (div_done),
    .quo  (div_quo)
  );

  rbc_slab_combine u_comb (
    .dot(dot_q),
    .rcp(rcp_q),
    .c_a(pla_q),
    .c_b(plb_q),
    .hit(comb_hit),
    .len(comb_len)
  );

  always_comb begin
    st_d      = st_q;
    ax_d      = ax_q;
    dot_d     = dot_q;
    rcp_d     = rcp_q;
    hit_d     = hit_q;
    len_d     = len_q;
    div_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (in_valid) begin
          dot_d = dot_w;
          ax_d  = '0;
          st_d  = ST_DIV;
        end
      end
      ST_DIV: begin
        if (cur_dot == '0) begin
          rcp_d[ax_q] = '0;
          if (last_ax) st_d = ST_COMB;
          else         ax_d = ax_q + AXW'(1);
        end else begin
          div_start = 1'b1;
          st_d      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (div_done) begin
          rcp_d[ax_q] = rcp_new;
          if (last_ax) st_d = ST_COMB;
          else begin
            ax_d = ax_q + AXW'(1);
            st_d = ST_DIV;
          end
        end
      end
      ST_COMB: begin
        hit_d = comb_hit;
        len_d = comb_len;
        st_d  = ST_OUT;
      end
      ST_OUT: begin
        if (out_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ax_q  <= '0;
      hit_q <= 1'b0;
      len_q <= '0;
      for (int a = 0; a < NAXIS; a++) begin
        dot_q[a] <= '0;
        rcp_q[a] <= '0;
      end
    end else begin
      st_q  <= st_d;
      ax_q  <= ax_d;
      hit_q <= hit_d;
      len_q <= len_d;
      dot_q <= dot_d;
      rcp_q <= rcp_d;
    end
  end

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_OUT);
  assign out_hit   = hit_q;
  assign out_len   = len_q;
endmodule

// File: rtl/rbc_chk.sv
module rbc_chk
  import rbc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_hit,
  input logic [FX_W-1:0] out_len
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_len))); // R3

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_MISS_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_len == '0)); // R9

  AST_HIT_LEN_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> !out_len[FX_W-1]); // R8
endmodule

bind ray_box_chord rbc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_hit  (out_hit),
  .out_len  (out_len)
);

// File: tb/ray_box_chord_tb_top.sv
module ray_box_chord_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_dir_x = '0, in_dir_y = '0, in_dir_z = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_hit;
  logic [15:0] out_len;

  int total = 0;
  int bad   = 0;

  longint box_n [3][3];
  longint box_c [3][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ray_box_chord dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir_x(in_dir_x), .in_dir_y(in_dir_y), .in_dir_z(in_dir_z),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_len(out_len)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // integer model built from R4..R9
  task automatic model(input longint dx, input longint dy, input longint dz,
                       output longint hit, output longint len);
    longint tin, tout, ok;
    tin = -32768; tout = 32767; ok = 1;
    for (int a = 0; a < 3; a++) begin
      longint d, q, ta, tb, en, ex;
      d = sat16((box_n[a][0]*dx + box_n[a][1]*dy + box_n[a][2]*dz) >>> 8);
      if (d == 0) begin
        longint lo, hi;
        lo = (box_c[a][0] < box_c[a][1]) ? box_c[a][0] : box_c[a][1];
        hi = (box_c[a][0] < box_c[a][1]) ? box_c[a][1] : box_c[a][0];
        if (!(lo <= 0 && hi >= 0)) ok = 0;
        en = -32768; ex = 32767;
      end else begin
        q = 65536 / ((d < 0) ? -d : d);
        if (q > 32767) q = 32767;
        if (d < 0) q = -q;
        ta = sat16((box_c[a][0]*q) >>> 8);
        tb = sat16((box_c[a][1]*q) >>> 8);
        en = (ta < tb) ? ta : tb;
        ex = (ta < tb) ? tb : ta;
      end
      if (en > tin) tin = en;
      if (ex < tout) tout = ex;
    end
    hit = (ok != 0 && tin <= tout && tout >= 0) ? 1 : 0;
    len = hit ? sat16(tout - tin) : 0;
  endtask

  task automatic cfg_write(input int addr, input longint val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < 9) box_n[addr/3][addr%3] = val;
    else if (addr < 15) box_c[(addr-9)/2][(addr-9)%2] = val;
  endtask

  // sends one ray, checks handshake (R2, R3) and result against the model
  task automatic run_ray(input string req, input longint dx, input longint dy,
                         input longint dz, output longint hit, output longint len);
    longint eh, el;
    int waited;
    logic h0; logic [15:0] l0;
    model(dx, dy, dz, eh, el);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_dir_x = 16'(dx); in_dir_y = 16'(dy); in_dir_z = 16'(dz);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 in_ready low after accept", longint'(in_ready), 0);
    waited = 0;
    while (!out_valid && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    check("R2 result produced", longint'(out_valid), 1);
    h0 = out_hit; l0 = out_len;
    repeat (2) @(negedge clk);
    check("R3 held valid", longint'(out_valid), 1);
    check("R3 held result", longint'({out_hit, out_len}), longint'({h0, l0}));
    hit = longint'(out_hit);
    len = longint'($signed(out_len));
    check({req, " hit"}, hit, eh);
    check({req, " len"}, len, el);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R3 taken", longint'(out_valid), 0);
    check("R2 ready again", longint'(in_ready), 1);
  endtask

  task automatic t_reset();
    longint h, l;
    check("R10 in_ready after reset", longint'(in_ready), 1);
    check("R10 out_valid after reset", longint'(out_valid), 0);
    // all-zero box: every axis parallel with origin on its planes -> clamp
    run_ray("R10 R7 R9 zero box", 256, 0, 0, h, l);
    check("R9 length clamp", l, 32767);
  endtask

  task automatic load_axis_box();
    // x in [1,3], y in [-1,1], z in [-1,1], unit axis normals
    for (int a = 0; a < 3; a++)
      for (int k = 0; k < 3; k++) cfg_write(a*3 + k, (a == k) ? 256 : 0);
    cfg_write(9, 256);   cfg_write(10, 768);
    cfg_write(11, -256); cfg_write(12, 256);
    cfg_write(13, -256); cfg_write(14, 256);
  endtask

  task automatic t_axis_hit();
    longint h, l;
    run_ray("R1 R6 R8 axis ray", 256, 0, 0, h, l);
    check("R9 axis chord 2.0", l, 512);
    check("R8 axis hit", h, 1);
  endtask

  task automatic t_behind();
    longint h, l;
    run_ray("R8 box behind origin", -256, 0, 0, h, l);
    check("R9 miss len", l, 0);
  endtask

  task automatic t_parallel_out();
    longint h, l;
    run_ray("R7 parallel outside slab", 0, 256, 0, h, l);
    check("R7 miss", h, 0);
  endtask

  task automatic t_graze();
    longint h, l;
    run_ray("R8 edge graze", 181, 181, 0, h, l);
    check("R8 equal entry exit hit", h, 1);
    check("R9 zero chord", l, 0);
  endtask

  task automatic t_tiny();
    longint h, l;
    run_ray("R5 reciprocal clamp", 1, 0, 0, h, l);
  endtask

  task automatic t_ignored_addr();
    longint h, l;
    cfg_write(15, 12345);
    run_ray("R1 address 15 ignored", 256, 0, 0, h, l);
    check("R1 chord unchanged", l, 512);
  endtask

  task automatic t_dot_sat();
    longint h, l;
    cfg_write(0, 32767);
    run_ray("R4 dot clamp", 32767, 100, 0, h, l);
    cfg_write(0, 256);
  endtask

  task automatic t_sweep();
    logic [15:0] s = 16'hACE1;
    longint h, l;
    for (int i = 0; i < 16; i++) begin
      longint c[3];
      for (int k = 0; k < 3; k++) begin
        s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        c[k] = longint'($signed(s[8:0]));
      end
      run_ray("R4 R5 R6 R8 sweep", c[0], c[1], c[2], h, l);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 3; a++) begin
      for (int k = 0; k < 3; k++) box_n[a][k] = 0;
      box_c[a][0] = 0; box_c[a][1] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_axis_box();
    t_axis_hit();
    t_behind();
    t_parallel_out();
    t_graze();
    t_tiny();
    t_ignored_addr();
    t_dot_sat();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule